// File: doc/BRIEF.md
# Linked-List Summation Engine

The engine walks a singly linked list stored in a small internal memory and adds up the value field of every node it visits. Each node takes two consecutive words. The word at pointer `p` holds the node's value, and the word at `p + 1` holds the pointer to the following node. A pointer of zero ends the list. Word 0 of the memory holds the head pointer, so a zero there means the list is empty.

Memory is loaded through a synchronous write port while the engine is idle. A one-cycle `start_i` pulse then launches a walk. A small controller steps a datapath made of a running-sum register, a pointer register, an incrementer, an address select that picks either the pointer or the pointer plus one, an accumulating adder and a zero test on the pointer. When the walk reaches the end of the list, `done_o` pulses for one cycle. `sum_o` then holds the total, wrapped to the data width, until the next start.

The data width `DATA_W` defaults to 8 and can be raised to 16 or 32 with no change to the source. The memory depth is `2**ADDR_W`, and `ADDR_W` must be smaller than `DATA_W`.

Top module: `list_sum_engine`

## Requirements
- R1: While `rst_ni` is low, `sum_o` reads 0 and `done_o` reads 0.
- R2: After a walk, `sum_o` equals the sum of all node values in list order, taken modulo 2^DATA_W, with any carry out discarded. A node at pointer p has its value at word p and its successor pointer at word p+1.
- R3: When word 0 holds 0 (an empty list), the walk ends with `done_o` after a single step, and `sum_o` reads 0.
- R4: `done_o` is high for exactly one cycle per walk and is never high without a preceding start.
- R5: If the clock edge that samples `start_i` is edge k and the list has n nodes, then `done_o` is high in the cycle that follows edge k+1+2n.
- R6: While the engine is idle and `start_i` is low, `sum_o` does not change, including while the memory is being written.
- R7: A `start_i` pulse that arrives while a walk is in progress is ignored. The running walk finishes with its own sum and its own latency.
- R8: Each accepted start clears the sum first, so the result of a walk never includes values from an earlier walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that launches a walk when idle |
| wr_en_i | input | 1 | Memory write enable, used only while idle |
| wr_addr_i | input | ADDR_W | Memory write address |
| wr_data_i | input | DATA_W | Memory write data |
| sum_o | output | DATA_W | Running sum, final once `done_o` has pulsed |
| done_o | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The assertions rely on the list being acyclic and on every pointer p satisfying 1 <= p <= 2**ADDR_W-2, so that both words of each node fall inside the memory. They also rely on the memory being written only while the engine is idle. The bench meets these conditions in three ways. It clears the whole memory before each list is built. It places at most seven nodes in disjoint word pairs at odd addresses, visiting them in a scrambled order. It issues writes only after the previous walk has produced `done_o`. The only stimulus the bench sends during a walk is the stray start pulse used for R7.

// File: rtl/lsum_pkg.sv
package lsum_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_VAL, ST_PTR} state_e;

  typedef struct packed {
    logic sum_sel_add;   // 1: adder result, 0: zero
    logic ld_sum;
    logic next_sel_mem;  // 1: memory data, 0: zero
    logic ld_next;
    logic addr_sel_inc;  // 1: next+1, 0: next
  } ctrl_t;
endpackage

// File: rtl/lsum_mem.sv
module lsum_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lsum_datapath.sv
module lsum_datapath
  import lsum_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              next_zero_o,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] sum_q, sum_d, next_q, next_d, next_inc, addr_full;

  assign sum_d       = ctrl_i.sum_sel_add ? sum_q + rdata_i : '0;
  assign next_d      = ctrl_i.next_sel_mem ? rdata_i : '0;
  assign next_zero_o = (next_d == '0);
  assign next_inc    = next_q + 1'b1;
  assign addr_full   = ctrl_i.addr_sel_inc ? next_inc : next_q;
  assign raddr_o     = addr_full[ADDR_W-1:0];

  generate
    if (ADDR_W < DATA_W) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr_full[DATA_W-1:ADDR_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      next_q <= '0;
    end else begin
      if (ctrl_i.ld_sum)  sum_q  <= sum_d;
      if (ctrl_i.ld_next) next_q <= next_d;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/lsum_ctrl.sv
module lsum_ctrl
  import lsum_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   next_zero_i,
  output ctrl_t  ctrl_o,
  output state_e state_o,
  output logic   done_o
);
  state_e state_q, state_d;
  logic   fin, done_q;

  always_comb begin
    ctrl_o  = '0;
    state_d = state_q;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ctrl_o.ld_sum  = 1'b1;  // select zero
        ctrl_o.ld_next = 1'b1;  // select zero, head read from word 0
        state_d        = ST_HEAD;
      end
      ST_HEAD: begin
        ctrl_o.next_sel_mem = 1'b1;
        ctrl_o.ld_next      = 1'b1;
        if (next_zero_i) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_VAL;
        end
      end
      ST_VAL: begin
        ctrl_o.sum_sel_add = 1'b1;
        ctrl_o.ld_sum      = 1'b1;
        state_d            = ST_PTR;
      end
      ST_PTR: begin
        ctrl_o.addr_sel_inc = 1'b1;
        ctrl_o.next_sel_mem = 1'b1;
        ctrl_o.ld_next      = 1'b1;
        if (next_zero_i) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_VAL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/list_sum_engine.sv
module list_sum_engine
  import lsum_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              done_o
);
  ctrl_t             ctrl;
  state_e            ctl_state;
  logic              next_zero, busy;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;

  assign busy = (ctl_state != ST_IDLE);

  lsum_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .next_zero_i(next_zero),
    .ctrl_o     (ctrl),
    .state_o    (ctl_state),
    .done_o     (done_o)
  );

  lsum_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .rdata_i    (rdata),
    .raddr_o    (raddr),
    .next_zero_o(next_zero),
    .sum_o      (sum_o)
  );

  lsum_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );
endmodule

// File: rtl/lsum_chk.sv
module lsum_chk
  import lsum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [DATA_W-1:0] sum_o,
  input logic              busy_w,
  input state_e            state_w,
  input logic              zero_w
);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_from_walk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_w && $past(busy_w)));

  assert_empty_list_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_HEAD && zero_w) |=> (done_o && !busy_w));

  assert_sum_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_w && !start_i) |=> $stable(sum_o));

  assert_start_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_w && start_i) |=> (sum_o == '0));

  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_VAL && start_i) |=> (state_w == ST_PTR));
endmodule

bind list_sum_engine lsum_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .done_o (done_o),
  .sum_o  (sum_o),
  .busy_w (busy),
  .state_w(ctl_state),
  .zero_w (next_zero)
);

// File: tb/tb_list_sum_engine.sv
`timescale 1ns/1ps
module tb_list_sum_engine;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] sum_o;
  logic          done_o;

  list_sum_engine #(.DATA_W(DW), .ADDR_W(AW)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  int unsigned cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct {
    logic [DW-1:0] sum;
    int unsigned   edge_no;
    string         tag;
  } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = DW'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic int slot(int i);
    return 1 + 2 * ((i * 3) % 7);
  endfunction

  // driver: builds a list, pushes expected result, launches the walk
  task automatic run_list(int n, int base, int step, bit poke, string tag);
    logic [DW-1:0] s = '0;
    for (int a = 0; a < DEPTH; a++) wr(a, 0);
    wr(0, (n == 0) ? 0 : slot(0));
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] v = DW'(base + i * step);
      wr(slot(i), int'(v));
      wr(slot(i) + 1, (i == n - 1) ? 0 : slot(i + 1));
      s += v;
    end
    @(negedge clk_i);
    start_i = 1'b1;
    exp_q.push_back('{s, cyc + 2 + 2 * n, tag});
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk_i);
    chk(sum_o == s, "R6", "sum held while idle", sum_o, s);
  endtask

  // monitor: pops expected items when done is seen
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "done without start", 1, 0);
        end else begin
          e = exp_q[0];
          chk(sum_o == e.sum, e.tag, "sum", sum_o, e.sum);
          chk(cyc == e.edge_no, "R5", "done edge", cyc, e.edge_no);
          @(negedge clk_i);
          chk(!done_o, "R4", "done width", done_o, 0);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sum_o == '0, "R1", "sum in reset", sum_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    rst_ni = 1'b1;
    run_list(3, 10, 5, 1'b0, "R2 three nodes");
    run_list(0, 0, 0, 1'b0, "R3 R8 empty after nonzero");
    run_list(7, 200, 61, 1'b0, "R2 wrap seven nodes");
    run_list(1, 255, 0, 1'b0, "R5 single node");
    run_list(5, 17, 33, 1'b1, "R7 start during walk");
    run_list(2, 128, 128, 1'b0, "R2 R8 carry discarded");
    run_list(4, 1, 2, 1'b0, "R8 fresh sum");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule